// File: doc/BRIEF.md
# USB Transmit Endpoint Buffer Controller

This block holds the outgoing data of one transmit endpoint of a full-speed USB function. Firmware loads bytes one at a time through a data port while the endpoint is filling. A separate command write then arms the endpoint. An armed endpoint that holds no bytes stands for a zero-length packet. When the protocol engine reports an IN token aimed at this endpoint, the block announces a packet and gives its length and the DATA0/DATA1 selection chosen by firmware. It then hands the buffered bytes to the packet transmitter over a valid/ready byte stream.

The transmitter reports the host's answer on two inputs. An acknowledge empties the buffer, disarms the endpoint and raises a sticky completion flag. A timeout rewinds the read position so the same packet goes out again on the next IN. An IN that arrives while the endpoint is not armed produces a NAK request. A command bit makes the endpoint deaf to IN tokens. A flush bit empties the buffer from any state. A two-bit field sets a low-level threshold for a warning output. The buffer depth `DEPTH` is a power of two from 8 to 32.

Top module: `txEndpointFifo`

## Requirements
- R1: After reset the buffer is empty (`fifoCount` 0, `fifoEmpty` 1), the endpoint is not armed, `doneOut` is 0, and `txValid`, `pktStart` and `nakOut` are 0.
- R2: A `dataWrEn` pulse while filling adds one byte and raises `fifoCount` by one. Data writes are ignored while the endpoint is armed or the buffer is full. `fifoCount` never exceeds `DEPTH`.
- R3: A command write with bit 0 (arm) set moves a filling endpoint to armed (`armedOut` 1). If no byte was loaded, the armed packet has length zero and streams no bytes.
- R4: An IN token to an armed endpoint that is not deaf gives, one cycle later, a one-cycle `pktStart` with `pktLen` equal to the number of stored bytes and `pktToggle` equal to command bit 1 (0 selects DATA0, 1 selects DATA1).
- R5: After `pktStart`, the bytes leave on `txData` in write order, one per cycle in which `txValid` and `txReady` are both high. `txLast` marks the final byte, and each byte taken lowers `fifoCount` by one.
- R6: An IN token while the endpoint is filling gives a one-cycle `nakOut` one cycle later and no packet. This includes an IN in the same cycle as the arming write.
- R7: While command bit 3 (deaf) is set, IN tokens produce neither `nakOut` nor `pktStart`, and an armed endpoint stays armed with its bytes intact.
- R8: An `ackIn` after a packet has been sent empties the buffer, disarms the endpoint and sets `doneOut`. `doneOut` stays set until a `doneClr` pulse.
- R9: A `timeoutIn` after a packet has been sent restores `fifoCount` to the packet length and keeps the endpoint armed. The next IN resends the same bytes.
- R10: A command write with bit 2 (flush) set empties the buffer and disarms the endpoint from any state. If bit 0 is set in the same write, the endpoint ends up armed with a zero-length packet.
- R11: `warnOut` is 1 exactly when `fifoCount` <= (W+1)*DEPTH/8, where W is command bits 5:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataWrEn | input | 1 | Write strobe for one data byte |
| dataWrByte | input | 8 | Data byte to store |
| cmdWrEn | input | 1 | Command write strobe |
| cmdWrByte | input | 6 | Command: [0] arm, [1] toggle, [2] flush, [3] deaf, [5:4] warning level |
| doneClr | input | 1 | Clears the completion flag |
| inToken | input | 1 | IN token addressed to this endpoint |
| ackIn | input | 1 | Host acknowledged the packet |
| timeoutIn | input | 1 | Host answer timed out |
| txReady | input | 1 | Transmitter accepts a byte |
| txValid | output | 1 | Byte on txData is valid |
| txData | output | 8 | Outgoing byte |
| txLast | output | 1 | Current byte ends the packet |
| pktStart | output | 1 | One-cycle packet announcement |
| pktLen | output | $clog2(DEPTH)+1 | Length of the announced packet |
| pktToggle | output | 1 | Data PID select of the announced packet |
| nakOut | output | 1 | Request to answer NAK |
| fifoCount | output | $clog2(DEPTH)+1 | Bytes held |
| fifoEmpty | output | 1 | No bytes held |
| fifoFull | output | 1 | DEPTH bytes held |
| warnOut | output | 1 | Level at or below the warning threshold |
| armedOut | output | 1 | Endpoint armed or sending |
| doneOut | output | 1 | Sticky packet-acknowledged flag |

## Verification
An arming command write and an IN token can land in the same clock cycle. The bench drives both strobes on one edge. It expects a NAK and no packet announcement, and it expects the endpoint to be armed afterwards. The next IN must then announce the packet with the right length, and the scoreboard must see its bytes. A second overlap is a flush and an arm in one command write. This must leave the endpoint armed with a zero-length packet, which the bench confirms through `pktLen` and through the absence of streamed bytes.

// File: rtl/txEpPkg.sv
package txEpPkg;

  // command byte layout
  localparam int CMD_W      = 6;
  localparam int CMD_ARM    = 0;
  localparam int CMD_TOGGLE = 1;
  localparam int CMD_FLUSH  = 2;
  localparam int CMD_DEAF   = 3;
  localparam int CMD_WARN_LO = 4;

  typedef enum logic [1:0] {
    ST_FILL   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SEND   = 2'd2,
    ST_RESULT = 2'd3
  } epState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic markStart;
    logic rewind;
    logic clear;
  } dpStrobe_t;

endpackage

// File: rtl/txEpDatapath.sv
module txEpDatapath
  import txEpPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [7:0]       wrByte,
  output logic [7:0]       rdByte,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] wrPtr;
  logic [CNT_W-1:0] rdPtr;
  logic [CNT_W-1:0] startPtr;

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.clear) begin
      mem[wrPtr[PTR_W-1:0]] <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      startPtr <= '0;
    end else begin
      if (strobe.push) begin
        wrPtr <= wrPtr + CNT_W'(1);
      end
      if (strobe.rewind) begin
        rdPtr <= startPtr;
      end else if (strobe.pop) begin
        rdPtr <= rdPtr + CNT_W'(1);
      end
      if (strobe.markStart) begin
        startPtr <= rdPtr;
      end
    end
  end

  assign count  = wrPtr - rdPtr;
  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign rdByte = mem[rdPtr[PTR_W-1:0]];

endmodule

// File: rtl/txEpControl.sv
module txEpControl
  import txEpPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int STEP  = DEPTH / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWrEn,
  input  logic             cmdWrEn,
  input  logic [CMD_W-1:0] cmdWrByte,
  input  logic             doneClr,
  input  logic             inToken,
  input  logic             ackIn,
  input  logic             timeoutIn,
  input  logic             txReady,
  input  logic [CNT_W-1:0] count,
  input  logic             empty,
  input  logic             full,
  output dpStrobe_t        strobe,
  output logic             txValid,
  output logic             txLast,
  output logic             pktStart,
  output logic [CNT_W-1:0] pktLen,
  output logic             pktToggle,
  output logic             nakOut,
  output logic             warnOut,
  output logic             armed,
  output logic             done
);

  epState_t         state, stateNext;
  logic             toggleBit, deafBit;
  logic [1:0]       warnSel;
  logic             doneQ, nakQ, pktStartQ, pktToggleQ;
  logic [CNT_W-1:0] pktLenQ;
  logic             flushReq, armReq, accept, nakReq, ackSeen;
  logic [CNT_W-1:0] warnLimit;

  assign flushReq = cmdWrEn && cmdWrByte[CMD_FLUSH];
  assign armReq   = cmdWrEn && cmdWrByte[CMD_ARM];
  assign accept   = (state == ST_WAIT) && inToken && !deafBit && !flushReq;
  assign nakReq   = (state == ST_FILL) && inToken && !deafBit;
  assign ackSeen  = (state == ST_RESULT) && ackIn;

  assign txValid = (state == ST_SEND) && !empty;
  assign txLast  = txValid && (count == CNT_W'(1));

  always_comb begin
    stateNext        = state;
    strobe           = '0;
    strobe.push      = dataWrEn && (state == ST_FILL) && !full;
    strobe.pop       = txValid && txReady;
    case (state)
      ST_FILL: begin
        if (armReq) begin
          stateNext        = ST_WAIT;
          strobe.markStart = 1'b1;
        end
      end
      ST_WAIT: begin
        if (accept) stateNext = ST_SEND;
      end
      ST_SEND: begin
        if (empty) stateNext = ST_RESULT;
      end
      ST_RESULT: begin
        if (ackIn) begin
          stateNext    = ST_FILL;
          strobe.clear = 1'b1;
        end else if (timeoutIn) begin
          stateNext     = ST_WAIT;
          strobe.rewind = 1'b1;
        end
      end
      default: stateNext = ST_FILL;
    endcase
    if (flushReq) begin
      strobe.clear     = 1'b1;
      strobe.markStart = 1'b0;
      strobe.rewind    = 1'b0;
      stateNext        = armReq ? ST_WAIT : ST_FILL;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_FILL;
      toggleBit  <= 1'b0;
      deafBit    <= 1'b0;
      warnSel    <= 2'd0;
      doneQ      <= 1'b0;
      nakQ       <= 1'b0;
      pktStartQ  <= 1'b0;
      pktToggleQ <= 1'b0;
      pktLenQ    <= '0;
    end else begin
      state     <= stateNext;
      nakQ      <= nakReq;
      pktStartQ <= accept;
      if (accept) begin
        pktLenQ    <= count;
        pktToggleQ <= toggleBit;
      end
      if (cmdWrEn) begin
        toggleBit <= cmdWrByte[CMD_TOGGLE];
        deafBit   <= cmdWrByte[CMD_DEAF];
        warnSel   <= cmdWrByte[CMD_WARN_LO +: 2];
      end
      if (ackSeen) begin
        doneQ <= 1'b1;
      end else if (doneClr) begin
        doneQ <= 1'b0;
      end
    end
  end

  assign warnLimit = CNT_W'({1'b0, warnSel} + 3'd1) * CNT_W'(STEP);
  assign warnOut   = (count <= warnLimit);

  assign pktStart  = pktStartQ;
  assign pktLen    = pktLenQ;
  assign pktToggle = pktToggleQ;
  assign nakOut    = nakQ;
  assign armed     = (state != ST_FILL);
  assign done      = doneQ;

endmodule

// File: rtl/txEndpointFifo.sv
module txEndpointFifo
  import txEpPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWrEn,
  input  logic [7:0]       dataWrByte,
  input  logic             cmdWrEn,
  input  logic [CMD_W-1:0] cmdWrByte,
  input  logic             doneClr,
  input  logic             inToken,
  input  logic             ackIn,
  input  logic             timeoutIn,
  input  logic             txReady,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             txLast,
  output logic             pktStart,
  output logic [CNT_W-1:0] pktLen,
  output logic             pktToggle,
  output logic             nakOut,
  output logic [CNT_W-1:0] fifoCount,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic             warnOut,
  output logic             armedOut,
  output logic             doneOut
);

  dpStrobe_t strobe;

  txEpDatapath #(.DEPTH(DEPTH)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrByte (dataWrByte),
    .rdByte (txData),
    .count  (fifoCount),
    .empty  (fifoEmpty),
    .full   (fifoFull)
  );

  txEpControl #(.DEPTH(DEPTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .dataWrEn  (dataWrEn),
    .cmdWrEn   (cmdWrEn),
    .cmdWrByte (cmdWrByte),
    .doneClr   (doneClr),
    .inToken   (inToken),
    .ackIn     (ackIn),
    .timeoutIn (timeoutIn),
    .txReady   (txReady),
    .count     (fifoCount),
    .empty     (fifoEmpty),
    .full      (fifoFull),
    .strobe    (strobe),
    .txValid   (txValid),
    .txLast    (txLast),
    .pktStart  (pktStart),
    .pktLen    (pktLen),
    .pktToggle (pktToggle),
    .nakOut    (nakOut),
    .warnOut   (warnOut),
    .armed     (armedOut),
    .done      (doneOut)
  );

endmodule

// File: rtl/txEpChecker.sv
module txEpChecker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inToken,
  input logic             ackIn,
  input logic             txReady,
  input logic             txValid,
  input logic             txLast,
  input logic             pktStart,
  input logic             nakOut,
  input logic [CNT_W-1:0] fifoCount,
  input logic             fifoEmpty,
  input logic             armedOut,
  input logic             doneOut
);

  // R2
  count_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  // R4
  start_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktStart |-> ($past(inToken) && armedOut));

  // R6
  nak_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    nakOut |-> ($past(inToken) && !pktStart));

  // R5
  last_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txLast) |=> fifoEmpty);

  // R5
  valid_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (armedOut && !fifoEmpty));

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneOut) |-> $past(ackIn));

endmodule

bind txEndpointFifo txEpChecker #(.DEPTH(DEPTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inToken   (inToken),
  .ackIn     (ackIn),
  .txReady   (txReady),
  .txValid   (txValid),
  .txLast    (txLast),
  .pktStart  (pktStart),
  .nakOut    (nakOut),
  .fifoCount (fifoCount),
  .fifoEmpty (fifoEmpty),
  .armedOut  (armedOut),
  .doneOut   (doneOut)
);

// File: tb/sim_txEndpointFifo.sv
`timescale 1ns/1ps
module sim_txEndpointFifo;

  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataWrEn = 1'b0;
  logic [7:0] dataWrByte = '0;
  logic cmdWrEn = 1'b0;
  logic [5:0] cmdWrByte = '0;
  logic doneClr = 1'b0, inToken = 1'b0, ackIn = 1'b0, timeoutIn = 1'b0;
  logic txReady = 1'b1;
  logic txValid, txLast, pktStart, pktToggle, nakOut;
  logic [7:0] txData;
  logic [CNT_W-1:0] pktLen, fifoCount;
  logic fifoEmpty, fifoFull, warnOut, armedOut, doneOut;

  int testCnt = 0;
  int failCnt = 0;
  logic [8:0] expQ[$];   // {last, byte}

  always #5 clk = ~clk;

  txEndpointFifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .dataWrEn(dataWrEn), .dataWrByte(dataWrByte),
    .cmdWrEn(cmdWrEn), .cmdWrByte(cmdWrByte), .doneClr(doneClr),
    .inToken(inToken), .ackIn(ackIn), .timeoutIn(timeoutIn), .txReady(txReady),
    .txValid(txValid), .txData(txData), .txLast(txLast), .pktStart(pktStart),
    .pktLen(pktLen), .pktToggle(pktToggle), .nakOut(nakOut),
    .fifoCount(fifoCount), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .warnOut(warnOut), .armedOut(armedOut), .doneOut(doneOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // scoreboard monitor: every accepted byte must match the queue head
  always @(negedge clk) begin
    if (rstN && txValid && txReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R5 unexpected byte", int'(txData), -1);
      end else begin
        logic [8:0] e;
        e = expQ.pop_front();
        chkEq("R5 byte order", int'(txData), int'(e[7:0]));
        chkEq("R5 last marker", int'(txLast), int'(e[8]));
      end
    end
  end

  task automatic expectPkt(input logic [7:0] b[$]);
    foreach (b[i]) expQ.push_back({(i == b.size() - 1) ? 1'b1 : 1'b0, b[i]});
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk); dataWrEn = 1'b1; dataWrByte = b;
    @(negedge clk); dataWrEn = 1'b0;
  endtask

  task automatic writeCmd(input logic [5:0] c);
    @(negedge clk); cmdWrEn = 1'b1; cmdWrByte = c;
    @(negedge clk); cmdWrEn = 1'b0;
  endtask

  task automatic pulseIn();
    @(negedge clk); inToken = 1'b1;
    @(negedge clk); inToken = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); ackIn = 1'b1;
    @(negedge clk); ackIn = 1'b0;
  endtask

  task automatic pulseTimeout();
    @(negedge clk); timeoutIn = 1'b1;
    @(negedge clk); timeoutIn = 1'b0;
  endtask

  task automatic pulseDoneClr();
    @(negedge clk); doneClr = 1'b1;
    @(negedge clk); doneClr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    logic [7:0] pkt[$];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 count", int'(fifoCount), 0);
    chkEq("R1 empty", int'(fifoEmpty), 1);
    chkEq("R1 armed", int'(armedOut), 0);
    chkEq("R1 done", int'(doneOut), 0);
    chkEq("R1 outputs", int'({txValid, pktStart, nakOut}), 0);
    chkEq("R11 warn at zero", int'(warnOut), 1);

    // R6 IN while filling
    pulseIn();
    chkEq("R6 nak", int'(nakOut), 1);
    chkEq("R6 no packet", int'(pktStart), 0);

    // R2 / R11: warn level 1 -> threshold 4
    writeCmd(6'h10);
    pkt = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4};
    for (int i = 0; i < 4; i++) writeByte(pkt[i]);
    chkEq("R11 warn at limit", int'(warnOut), 1);
    writeByte(pkt[4]);
    chkEq("R11 warn above limit", int'(warnOut), 0);
    chkEq("R2 count", int'(fifoCount), 5);
    writeCmd(6'h11);
    chkEq("R3 armed", int'(armedOut), 1);
    writeByte(8'hEE);
    chkEq("R2 write ignored when armed", int'(fifoCount), 5);
    expectPkt(pkt);
    pulseIn();
    chkEq("R4 start", int'(pktStart), 1);
    chkEq("R4 length", int'(pktLen), 5);
    chkEq("R4 toggle", int'(pktToggle), 0);
    idle(8);
    chkEq("R5 drained", int'(fifoCount), 0);
    chkEq("R5 valid low", int'(txValid), 0);
    pulseAck();
    chkEq("R8 done", int'(doneOut), 1);
    chkEq("R8 disarmed", int'(armedOut), 0);
    chkEq("R8 count", int'(fifoCount), 0);
    pulseDoneClr();
    chkEq("R8 done cleared", int'(doneOut), 0);

    // R9 retransmission with DATA1
    writeCmd(6'h02);
    pkt = '{8'h51, 8'h52, 8'h53};
    foreach (pkt[i]) writeByte(pkt[i]);
    writeCmd(6'h03);
    expectPkt(pkt);
    pulseIn();
    chkEq("R4 toggle one", int'(pktToggle), 1);
    chkEq("R4 length three", int'(pktLen), 3);
    idle(6);
    pulseTimeout();
    chkEq("R9 count restored", int'(fifoCount), 3);
    chkEq("R9 still armed", int'(armedOut), 1);
    expectPkt(pkt);
    pulseIn();
    chkEq("R9 resend length", int'(pktLen), 3);
    idle(6);
    pulseAck();
    chkEq("R9 done after resend", int'(doneOut), 1);
    pulseDoneClr();

    // R3 zero-length packet
    writeCmd(6'h01);
    pulseIn();
    chkEq("R3 zlp start", int'(pktStart), 1);
    chkEq("R3 zlp length", int'(pktLen), 0);
    idle(3);
    pulseAck();
    chkEq("R3 zlp done", int'(doneOut), 1);
    pulseDoneClr();

    // R7 deaf mode
    writeCmd(6'h08);
    pulseIn();
    chkEq("R7 no nak", int'(nakOut), 0);
    writeByte(8'h77);
    writeCmd(6'h09);
    pulseIn();
    chkEq("R7 no packet", int'({pktStart, nakOut}), 0);
    chkEq("R7 kept armed", int'(armedOut), 1);
    chkEq("R7 kept bytes", int'(fifoCount), 1);
    writeCmd(6'h01);
    pkt = '{8'h77};
    expectPkt(pkt);
    pulseIn();
    chkEq("R7 sends after clear", int'(pktStart), 1);
    idle(4);
    pulseAck();

    // R10 flush
    for (int i = 0; i < 4; i++) writeByte(8'(i + 8'h10));
    writeCmd(6'h04);
    chkEq("R10 flushed count", int'(fifoCount), 0);
    chkEq("R10 flushed empty", int'(fifoEmpty), 1);
    writeByte(8'h21);
    writeByte(8'h22);
    writeCmd(6'h01);
    writeCmd(6'h05);
    chkEq("R10 flush+arm count", int'(fifoCount), 0);
    chkEq("R10 flush+arm armed", int'(armedOut), 1);
    pulseIn();
    chkEq("R10 zlp length", int'(pktLen), 0);
    idle(3);
    pulseAck();

    // R2 full
    for (int i = 0; i < DEPTH + 2; i++) writeByte(8'(i));
    chkEq("R2 full count", int'(fifoCount), DEPTH);
    chkEq("R2 full flag", int'(fifoFull), 1);
    writeCmd(6'h04);

    // R11 warn level 3 -> threshold 8
    writeCmd(6'h30);
    for (int i = 0; i < 8; i++) writeByte(8'(i));
    chkEq("R11 level3 at limit", int'(warnOut), 1);
    writeByte(8'h99);
    chkEq("R11 level3 above", int'(warnOut), 0);
    writeCmd(6'h04);

    // R6 arm and IN in the same cycle
    pkt = '{8'h31, 8'h32};
    foreach (pkt[i]) writeByte(pkt[i]);
    @(negedge clk); cmdWrEn = 1'b1; cmdWrByte = 6'h01; inToken = 1'b1;
    @(negedge clk); cmdWrEn = 1'b0; inToken = 1'b0;
    chkEq("R6 same-cycle nak", int'(nakOut), 1);
    chkEq("R6 same-cycle no start", int'(pktStart), 0);
    chkEq("R6 same-cycle armed", int'(armedOut), 1);
    expectPkt(pkt);
    pulseIn();
    chkEq("R4 start after overlap", int'(pktStart), 1);
    chkEq("R4 length after overlap", int'(pktLen), 2);
    idle(5);
    pulseAck();

    chkEq("R5 scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule